// File: doc/BRIEF.md
# Register-bus command sequencer

This block is a small bus master that executes a list of pre-encoded commands held in its own command store. Each entry is written over a load port. After a start pulse the entries run in order from index 0. An entry either issues a single register access on a simple request/response bus, blocks on an interrupt condition, or ends the list. Every request carries a 16-bit word address and a 32-bit data value. Each request stands alone, with no bursts. Read data and write completions come back on a separate response channel that carries a valid strobe and an error bit.

A read entry is a polling check. The returned data is ANDed with a mask and compared with an expected value. When it does not match, the read is repeated after a fixed idle gap, up to a bounded number of attempts. Two mode inputs soften the failure handling. With `ignore_poll`, one mismatch is accepted and the list goes on. With `continue_on_fail`, the list keeps running after the attempt limit, but the run is marked as failed. A write entry can ask to wait for its completion. Without that flag, the next request may follow on the very next cycle, and the response that comes later is consumed silently. When the list ends or hits a fatal condition, the block reports done together with pass or fail, and holds that result until the next start.

Top module: `cfg_bus_sequencer`

## Requirements
- R1: After reset and before any start pulse, `req_valid`, `done`, `pass` and `fail` are all 0.
- R2: Entry layout is {expected[95:64], arg[63:32], ctrl[31:0]}. ctrl[31:30] is the opcode: 0 for a bus access, 1 for an interrupt wait, 2 or 3 for end of list. For an access, ctrl[16] is 1 for a write and 0 for a read, and ctrl[17] requests waiting for write completion. For an interrupt wait, ctrl[1:0] selects the condition.
- R3: Accesses appear on the bus in list order, each held until accepted. `req_addr` = ctrl[15:0], `req_write` = ctrl[16], and a write's `req_wdata` = arg.
- R4: A write with ctrl[17]=0 lets the next request be accepted on the cycle right after its own acceptance.
- R5: A write with ctrl[17]=1 blocks any further request until its response arrives. With the test response latency of L cycles, the next acceptance comes L+2 cycles later. A response with `rsp_err`=1 ends the run with done and fail, and issues nothing more.
- R6: Responses belonging to non-waiting writes are consumed in order and never taken as the data of a later read.
- R7: A read passes when `rsp_err`=0 and (rdata AND arg) equals expected. A pass moves on to the next entry. An error response counts as a mismatch.
- R8: After a mismatching read, the read is reissued after exactly POLL_GAP idle cycles. With a one-cycle response, consecutive read acceptances are POLL_GAP+2 cycles apart.
- R9: After POLL_TRIES mismatching reads, and with neither mode input set, the run halts with done and fail.
- R10: With `continue_on_fail`=1, reaching the attempt limit moves on to the next entry. The finished run then reports fail=1 and pass=0.
- R11: With `ignore_poll`=1, a mismatching read is issued once, moves on, and does not affect pass.
- R12: Interrupt-wait conditions are 0 for level high, 1 for level low, 2 for a rising edge and 3 for a falling edge, where an edge is judged against the previous cycle's sample. No request is issued until the condition holds.
- R13: An interrupt wait still unmet after IRQ_TIMEOUT cycles ends the run with done and fail.
- R14: An end entry raises done with pass equal to the inverse of the accumulated fail. The result holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the list at entry 0 (taken when idle or finished) |
| ignore_poll | input | 1 | Accept a single read mismatch and move on |
| continue_on_fail | input | 1 | Keep running after the attempt limit, marking fail |
| ld_en | input | 1 | Write one command entry |
| ld_addr | input | $clog2(DEPTH) | Entry index to write |
| ld_data | input | 96 | Entry contents |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Word address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Response strobe |
| rsp_err | input | 1 | Response error |
| rsp_rdata | input | 32 | Read data |
| irq | input | 1 | Interrupt input (synchronous to clk) |
| done | output | 1 | Run finished |
| pass | output | 1 | Finished without failure |
| fail | output | 1 | Finished with failure |

## Verification
The main read-check loop gets several response streams. One matches at once. One never matches. One returns correct data flagged with an error and then matches on the third try. The same never-matching stream is run again under each mode input. Between them these separate the match rule, the attempt bound, the retry gap, and the three failure policies. Writes are driven both with and without the completion flag, behind a delayed response. Counting acceptance spacing then shows whether the block blocked or streamed. A pending write response that carries non-matching data shows whether responses were mis-attributed. The interrupt wait is driven through all four conditions, each first held in the state that must not release it. A never-arriving interrupt exercises the timeout.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [1:0] {
    OP_ACCESS  = 2'd0,
    OP_IRQ     = 2'd1,
    OP_END     = 2'd2,
    OP_END_ALT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    IRQ_HIGH = 2'd0,
    IRQ_LOW  = 2'd1,
    IRQ_RISE = 2'd2,
    IRQ_FALL = 2'd3
  } irq_cond_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_GAP,
    S_IRQ,
    S_DONE
  } st_e;

  localparam int CMD_W    = 96;
  localparam int WAIT_BIT = 17;
  localparam int WR_BIT   = 16;

  typedef struct packed {
    logic [31:0] expv;
    logic [31:0] arg;
    logic [31:0] ctrl;
  } cmd_t;

endpackage

// File: rtl/cseq_cmd_store.sv
module cseq_cmd_store
  import cseq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  cmd_t          wr_cmd,
  input  logic [AW-1:0] rd_idx,
  output cmd_t          rd_cmd
);

  cmd_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_cmd;
    end
  end

  assign rd_cmd = mem[rd_idx];

endmodule

// File: rtl/cseq_irq_watch.sv
module cseq_irq_watch
  import cseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      irq_in,
  input  irq_cond_e cond,
  output logic      hit
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= irq_in;
    end
  end

  always_comb begin
    unique case (cond)
      IRQ_HIGH: hit = irq_in;
      IRQ_LOW:  hit = !irq_in;
      IRQ_RISE: hit = irq_in && !prev_q;
      IRQ_FALL: hit = !irq_in && prev_q;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfg_bus_sequencer.sv
module cfg_bus_sequencer
  import cseq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int POLL_TRIES  = 50,
  parameter int POLL_GAP    = 4,
  parameter int IRQ_TIMEOUT = 4096,
  parameter int PEND_MAX    = 7,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ignore_poll,
  input  logic              continue_on_fail,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [CMD_W-1:0]  ld_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [15:0]       req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [31:0]       rsp_rdata,
  input  logic              irq,
  output logic              done,
  output logic              pass,
  output logic              fail
);

  localparam int TW = $clog2(POLL_TRIES + 1);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int MW = $clog2(IRQ_TIMEOUT + 1);
  localparam int PW = $clog2(PEND_MAX + 1);

  st_e           st_q, st_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [TW-1:0] tries_q, tries_d;
  logic [GW-1:0] gap_q, gap_d;
  logic [MW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          fail_q, fail_d;
  logic          done_q, done_d;

  cmd_t cmd;
  op_e  op;
  logic is_wr, wait_f, nowait_wr, pend_full, hs;
  logic pend_inc, pend_dec, own_rsp, poll_ok, last_try, irq_hit;
  logic unused_bits;

  cseq_cmd_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk    (clk),
    .wr_en  (ld_en),
    .wr_idx (ld_addr),
    .wr_cmd (cmd_t'(ld_data)),
    .rd_idx (pc_q),
    .rd_cmd (cmd)
  );

  cseq_irq_watch u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq),
    .cond   (irq_cond_e'(cmd.ctrl[1:0])),
    .hit    (irq_hit)
  );

  assign op          = op_e'(cmd.ctrl[31:30]);
  assign is_wr       = cmd.ctrl[WR_BIT];
  assign wait_f      = cmd.ctrl[WAIT_BIT];
  assign nowait_wr   = is_wr && !wait_f;
  assign unused_bits = ^cmd.ctrl[29:18];
  assign pend_full   = (pend_q == PW'(PEND_MAX));

  assign req_valid = (st_q == S_ISSUE) && (op == OP_ACCESS) && !(nowait_wr && pend_full);
  assign req_write = is_wr;
  assign req_addr  = cmd.ctrl[15:0];
  assign req_wdata = cmd.arg;
  assign hs        = req_valid && req_ready;

  // responses to streamed writes are retired first, in order
  assign pend_inc = hs && nowait_wr;
  assign pend_dec = rsp_valid && (pend_q != '0);
  assign pend_d   = pend_q + PW'(pend_inc) - PW'(pend_dec);
  assign own_rsp  = rsp_valid && (pend_q == '0) && (st_q == S_WAIT);

  assign poll_ok  = !rsp_err && ((rsp_rdata & cmd.arg) == cmd.expv);
  assign last_try = (tries_q == TW'(POLL_TRIES - 1));

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    tries_d = tries_q;
    gap_d   = gap_q;
    tmr_d   = tmr_q;
    fail_d  = fail_q;
    done_d  = done_q;
    unique case (st_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          st_d    = S_ISSUE;
          pc_d    = '0;
          tries_d = '0;
          fail_d  = 1'b0;
          done_d  = 1'b0;
        end
      end
      S_ISSUE: begin
        if (op == OP_ACCESS) begin
          if (hs) begin
            if (nowait_wr) pc_d = pc_q + 1'b1;
            else           st_d = S_WAIT;
          end
        end else if (op == OP_IRQ) begin
          st_d  = S_IRQ;
          tmr_d = '0;
        end else begin
          st_d   = S_DONE;
          done_d = 1'b1;
        end
      end
      S_WAIT: begin
        if (own_rsp) begin
          if (is_wr) begin
            if (rsp_err) begin
              st_d   = S_DONE;
              done_d = 1'b1;
              fail_d = 1'b1;
            end else begin
              st_d = S_ISSUE;
              pc_d = pc_q + 1'b1;
            end
          end else if (poll_ok || ignore_poll) begin
            st_d    = S_ISSUE;
            pc_d    = pc_q + 1'b1;
            tries_d = '0;
          end else if (last_try) begin
            tries_d = '0;
            fail_d  = 1'b1;
            if (continue_on_fail) begin
              st_d = S_ISSUE;
              pc_d = pc_q + 1'b1;
            end else begin
              st_d   = S_DONE;
              done_d = 1'b1;
            end
          end else begin
            tries_d = tries_q + 1'b1;
            gap_d   = '0;
            st_d    = S_GAP;
          end
        end
      end
      S_GAP: begin
        if (gap_q == GW'(POLL_GAP - 1)) st_d  = S_ISSUE;
        else                            gap_d = gap_q + 1'b1;
      end
      S_IRQ: begin
        if (irq_hit) begin
          st_d = S_ISSUE;
          pc_d = pc_q + 1'b1;
        end else if (tmr_q == MW'(IRQ_TIMEOUT - 1)) begin
          st_d   = S_DONE;
          done_d = 1'b1;
          fail_d = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      pc_q    <= '0;
      tries_q <= '0;
      gap_q   <= '0;
      tmr_q   <= '0;
      pend_q  <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pc_q    <= pc_d;
      tries_q <= tries_d;
      gap_q   <= gap_d;
      tmr_q   <= tmr_d;
      pend_q  <= pend_d;
      fail_q  <= fail_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;
  assign pass = done_q && !fail_q;
  assign fail = done_q && fail_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata));

  // R5
  wait_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) && !rsp_valid |=> !req_valid);

  // R9
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q < TW'(POLL_TRIES));

  // R13
  tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q < MW'(IRQ_TIMEOUT));

  // R14
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(pass) && $stable(fail));

endmodule

// File: tb/tb_cfg_bus_sequencer.sv
`timescale 1ns/1ps
module tb_cfg_bus_sequencer;
  localparam int DEPTH = 16;
  localparam int TRIES = 4;
  localparam int GAP   = 3;
  localparam int TMO   = 20;
  localparam int AW    = $clog2(DEPTH);

  logic clk, rst_n, start, ignore_poll, continue_on_fail;
  logic ld_en;
  logic [AW-1:0] ld_addr;
  logic [95:0] ld_data;
  logic req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic irq, done, pass, fail;

  cfg_bus_sequencer #(
    .DEPTH(DEPTH), .POLL_TRIES(TRIES), .POLL_GAP(GAP), .IRQ_TIMEOUT(TMO), .PEND_MAX(7)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ignore_poll(ignore_poll),
    .continue_on_fail(continue_on_fail), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .irq(irq), .done(done), .pass(pass), .fail(fail)
  );

  typedef struct { logic w; logic [15:0] a; logic [31:0] d; } req_t;
  typedef struct { int due; logic err; logic [31:0] data; } rsp_t;

  req_t exp_q[$];
  rsp_t rsp_q[$];
  logic [32:0] rd_q[$];
  int hs_cyc[$];
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int lat = 0;
  logic [31:0] rd_dflt = 32'h0;
  logic wr_err = 1'b0;
  bit fin = 1'b0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] c_acc(input logic wt, input logic wr, input logic [15:0] a);
    return {2'b00, 12'd0, wt, wr, a};
  endfunction
  function automatic logic [31:0] c_irq(input logic [1:0] c);
    return {2'b01, 28'd0, c};
  endfunction
  function automatic logic [31:0] c_end();
    return {2'b10, 30'd0};
  endfunction

  task automatic load(input int idx, input logic [31:0] c, input logic [31:0] arg, input logic [31:0] ev);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(idx); ld_data = {ev, arg, c};
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic expect_req(input logic w, input logic [15:0] a, input logic [31:0] d);
    req_t e;
    e.w = w; e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  task automatic pulse_start();
    hs_cyc.delete();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_prog(input int max_cyc);
    pulse_start();
    for (int i = 0; i < max_cyc && !done; i++) @(negedge clk);
  endtask

  // monitor (scoreboard pop) and responder
  always @(negedge clk) begin
    if (rsp_q.size() > 0 && rsp_q[0].due <= cyc) begin
      rsp_valid = 1'b1; rsp_err = rsp_q[0].err; rsp_rdata = rsp_q[0].data;
      void'(rsp_q.pop_front());
    end else begin
      rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = 32'h0;
    end
    if (rst_n && req_valid && req_ready) begin
      rsp_t r;
      hs_cyc.push_back(cyc);
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R3 actual=unexpected request addr %h expected=none", req_addr);
      end else begin
        req_t e;
        e = exp_q.pop_front();
        check("R3 write flag", {31'd0, req_write}, {31'd0, e.w});
        check("R3 address", {16'd0, req_addr}, {16'd0, e.a});
        if (e.w) check("R3 write data", req_wdata, e.d);
      end
      r.due = cyc + 1 + lat;
      if (req_write) begin
        r.err = wr_err; r.data = 32'hffff_ffff;
      end else if (rd_q.size() > 0) begin
        logic [32:0] v;
        v = rd_q.pop_front();
        r.err = v[32]; r.data = v[31:0];
      end else begin
        r.err = 1'b0; r.data = rd_dflt;
      end
      rsp_q.push_back(r);
    end
  end

  initial begin
    #1000000;
    if (!fin) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ignore_poll = 1'b0; continue_on_fail = 1'b0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0; req_ready = 1'b1; irq = 1'b0;
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check("R1 req_valid", {31'd0, req_valid}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 pass", {31'd0, pass}, 32'd0);
    check("R1 fail", {31'd0, fail}, 32'd0);

    // T1: waited write, streamed write, matching read (R2 R4 R5 R6 R14)
    lat = 4;
    load(0, c_acc(1'b1, 1'b1, 16'h0010), 32'h1234_c0de, 32'h0);
    load(1, c_acc(1'b0, 1'b1, 16'h0011), 32'h0000_da7a, 32'h0);
    load(2, c_acc(1'b0, 1'b0, 16'h0020), 32'h0000_00ff, 32'h0000_005a);
    load(3, c_end(), 32'h0, 32'h0);
    rd_q.push_back({1'b0, 32'h1234_565a});
    expect_req(1'b1, 16'h0010, 32'h1234_c0de);
    expect_req(1'b1, 16'h0011, 32'h0000_da7a);
    expect_req(1'b0, 16'h0020, 32'h0);
    run_prog(100);
    check("R14 done", {31'd0, done}, 32'd1);
    check("R14 pass", {31'd0, pass}, 32'd1);
    check("R6 no retry of read", exp_q.size(), 32'd0);
    check("R2 request count", hs_cyc.size(), 32'd3);
    if (hs_cyc.size() >= 3) begin
      check("R5 spacing after waited write", hs_cyc[1] - hs_cyc[0], lat + 2);
      check("R4 spacing after streamed write", hs_cyc[2] - hs_cyc[1], 32'd1);
    end
    repeat (5) @(negedge clk);
    check("R14 done held", {31'd0, done}, 32'd1);
    check("R14 pass held", {31'd0, pass}, 32'd1);
    lat = 0;

    // T2: read never matches, strict mode (R8 R9)
    load(0, c_acc(1'b0, 1'b0, 16'h0030), 32'h0000_ffff, 32'h0000_1234);
    load(1, c_acc(1'b1, 1'b1, 16'h0031), 32'h0000_0001, 32'h0);
    load(2, c_end(), 32'h0, 32'h0);
    rd_dflt = 32'h0;
    for (int i = 0; i < TRIES; i++) expect_req(1'b0, 16'h0030, 32'h0);
    run_prog(200);
    check("R9 done", {31'd0, done}, 32'd1);
    check("R9 fail", {31'd0, fail}, 32'd1);
    check("R9 pass", {31'd0, pass}, 32'd0);
    check("R9 read attempts", hs_cyc.size(), TRIES);
    if (hs_cyc.size() >= 4) begin
      check("R8 retry spacing", hs_cyc[1] - hs_cyc[0], GAP + 2);
      check("R8 retry spacing late", hs_cyc[3] - hs_cyc[2], GAP + 2);
    end
    repeat (5) @(negedge clk);
    check("R9 halted", hs_cyc.size(), TRIES);

    // T3: continue after limit (R10)
    continue_on_fail = 1'b1;
    for (int i = 0; i < TRIES; i++) expect_req(1'b0, 16'h0030, 32'h0);
    expect_req(1'b1, 16'h0031, 32'h0000_0001);
    run_prog(200);
    continue_on_fail = 1'b0;
    check("R10 all issued", exp_q.size(), 32'd0);
    check("R10 fail", {31'd0, fail}, 32'd1);
    check("R10 pass", {31'd0, pass}, 32'd0);

    // T4: ignore mismatch (R11)
    ignore_poll = 1'b1;
    expect_req(1'b0, 16'h0030, 32'h0);
    expect_req(1'b1, 16'h0031, 32'h0000_0001);
    run_prog(100);
    ignore_poll = 1'b0;
    check("R11 single read then write", hs_cyc.size(), 32'd2);
    check("R11 pass", {31'd0, pass}, 32'd1);

    // T5: error response then mismatch then match (R7)
    rd_q.push_back({1'b1, 32'h0000_1234});
    rd_q.push_back({1'b0, 32'h0000_ff00});
    rd_q.push_back({1'b0, 32'habcd_1234});
    for (int i = 0; i < 3; i++) expect_req(1'b0, 16'h0030, 32'h0);
    expect_req(1'b1, 16'h0031, 32'h0000_0001);
    run_prog(200);
    check("R7 requests", hs_cyc.size(), 32'd4);
    check("R7 pass", {31'd0, pass}, 32'd1);

    // T6: four interrupt conditions (R12)
    load(0, c_irq(2'd0), 32'h0, 32'h0);
    load(1, c_acc(1'b1, 1'b1, 16'h0040), 32'h1, 32'h0);
    load(2, c_irq(2'd1), 32'h0, 32'h0);
    load(3, c_acc(1'b1, 1'b1, 16'h0041), 32'h2, 32'h0);
    load(4, c_irq(2'd2), 32'h0, 32'h0);
    load(5, c_acc(1'b1, 1'b1, 16'h0042), 32'h3, 32'h0);
    load(6, c_irq(2'd3), 32'h0, 32'h0);
    load(7, c_acc(1'b1, 1'b1, 16'h0043), 32'h4, 32'h0);
    load(8, c_end(), 32'h0, 32'h0);
    for (int i = 0; i < 4; i++) expect_req(1'b1, 16'(16'h0040 + i), 32'(i + 1));
    irq = 1'b0;
    pulse_start();
    repeat (8) @(negedge clk);
    check("R12 high wait blocks", hs_cyc.size(), 32'd0);
    irq = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 high released", hs_cyc.size(), 32'd1);
    repeat (6) @(negedge clk);
    check("R12 low wait blocks", hs_cyc.size(), 32'd1);
    irq = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 low released", hs_cyc.size(), 32'd2);
    repeat (6) @(negedge clk);
    check("R12 rise wait blocks", hs_cyc.size(), 32'd2);
    irq = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 rise released", hs_cyc.size(), 32'd3);
    repeat (6) @(negedge clk);
    check("R12 fall wait blocks on steady high", hs_cyc.size(), 32'd3);
    irq = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 fall released", hs_cyc.size(), 32'd4);
    check("R12 pass", {31'd0, pass}, 32'd1);

    // T7: interrupt timeout (R13)
    load(0, c_irq(2'd0), 32'h0, 32'h0);
    load(1, c_acc(1'b1, 1'b1, 16'h0044), 32'h5, 32'h0);
    load(2, c_end(), 32'h0, 32'h0);
    pulse_start();
    repeat (15) @(negedge clk);
    check("R13 not yet timed out", {31'd0, done}, 32'd0);
    repeat (15) @(negedge clk);
    check("R13 timeout done", {31'd0, done}, 32'd1);
    check("R13 timeout fail", {31'd0, fail}, 32'd1);
    check("R13 nothing issued", hs_cyc.size(), 32'd0);

    // T8: waited write with error (R5)
    wr_err = 1'b1;
    load(0, c_acc(1'b1, 1'b1, 16'h0050), 32'h7, 32'h0);
    load(1, c_acc(1'b1, 1'b1, 16'h0051), 32'h8, 32'h0);
    load(2, c_end(), 32'h0, 32'h0);
    expect_req(1'b1, 16'h0050, 32'h7);
    run_prog(100);
    repeat (4) @(negedge clk);
    wr_err = 1'b0;
    check("R5 error halts", hs_cyc.size(), 32'd1);
    check("R5 error fail", {31'd0, fail}, 32'd1);
    check("R3 queue drained", exp_q.size(), 32'd0);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule